// File: doc/BRIEF.md
# Two-Wire Serial Memory Target with Page-Wrapped Writes

This block is a target on a two-wire serial bus (I2C) that fronts a 256-byte memory. The memory is split into 16 pages of 16 bytes each. The target answers to a 7-bit bus address made of a fixed five-bit prefix and two strap inputs, so four copies can share one bus. An internal 8-bit location counter selects the byte being accessed. A master can do three things. It can write a page, read from the current counter position, or set the counter and then read after a repeated start.

The two directions move through memory in different ways. Reads step the counter across the whole array. Writes only step the counter's low nibble, so they stay inside one page. Write data collects in a page buffer and is committed when the STOP arrives. An internal programming interval follows, and for that whole interval the target acknowledges nothing. A master finds out that the interval has ended by repeatedly sending its address until it gets an ACK.

SCL and SDA arrive on plain inputs. The only output is an enable that pulls SDA low, and the board supplies the pull-up.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset every memory byte reads 0xFF, the counter is 0, and SDA is released.
- R2: The target acknowledges only an address byte whose upper seven bits are 10100 followed by strap[1] and strap[0]. Bytes go MSB first, and bit 0 is R/W (1 = read). For any other address the target leaves SDA released.
- R3: Each byte sent on a read advances the counter by one across the whole array, and 0xFF is followed by 0x00.
- R4: On a write, each data byte advances only the low 4 bits of the counter, so a write that reaches the top of a page continues at the page base.
- R5: In a write of more than 16 data bytes, the later bytes overwrite the earlier bytes of the same page, and the last value written to each location is the one kept.
- R6: A write is the address with R/W=0, then one location byte, then data bytes. The target ACKs each of these, and the data reaches memory at the STOP.
- R7: A current-address read (address with R/W=1 and no location byte) returns data starting at the counter's present value.
- R8: A random read sends the location byte in a write phase, then a repeated START and the address with R/W=1. A write phase that carries no data bytes does not start a programming interval.
- R9: After a STOP that ends a write carrying data, the target does not acknowledge its address for BUSY_CYCLES clocks and keeps SDA released. After that it acknowledges again.
- R10: A master NACK on a read byte ends the read and releases SDA. The counter is left at the location after the last byte sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| strap | input | 2 | Low two bits of the bus address |
| sda_oe | output | 1 | High pulls SDA low |

## Verification
Some properties are checked by assertions on every cycle. SDA is only driven during an ACK slot or a data bit being sent. SDA stays released whenever the target is idle or busy. A busy interval always begins at a STOP. The page bits of the counter stay fixed while write data arrives. Every byte loaded for sending advances the counter by exactly one.

Other behaviour only shows up in the bench scenarios. These cover in-page wrap, overflow of a write past 16 bytes, the 255-to-0 read wrap, address polling during the programming interval, the counter position after a NACK, and the stored data itself. The bench checks each of these against a reference memory model.

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int          ADDR_W      = 8,
  parameter int          PAGE_W      = 4,
  parameter int          BUSY_CYCLES = 1500,
  parameter logic [4:0]  DEV_ID      = 5'b10100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap,
  output logic       sda_oe
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int HI_W   = ADDR_W - PAGE_W;
  localparam int BW     = $clog2(BUSY_CYCLES + 1);

  localparam logic [2:0] S_IDLE = 3'd0, S_RX = 3'd1, S_ACK = 3'd2, S_TX = 3'd3, S_RACK = 3'd4;
  localparam logic [1:0] K_DEV = 2'd0, K_MEM = 2'd1, K_DATA = 2'd2;

  logic [2:0]        scl_p, sda_p;
  logic [2:0]        state;
  logic [1:0]        kind;
  logic              rw, rnack;
  logic [3:0]        bitcnt;
  logic [7:0]        sr;
  logic [ADDR_W-1:0] ptr;
  logic [HI_W-1:0]   wpage;
  logic [7:0]        mem  [DEPTH];
  logic [7:0]        pbuf [PAGE_N];
  logic [PAGE_N-1:0] pvalid;
  logic [BW-1:0]     busy;

  wire start_c = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  wire stop_c  = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
  wire rise    = scl_p[1] & ~scl_p[2];
  wire fall    = ~scl_p[1] & scl_p[2];
  wire dev_hit = (sr[7:1] == {DEV_ID, strap}) && (busy == '0);
  wire [PAGE_W-1:0] lo = ptr[PAGE_W-1:0];

  assign sda_oe = (state == S_ACK) || (state == S_TX && !sr[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p  <= '1;
      sda_p  <= '1;
      state  <= S_IDLE;
      kind   <= K_DEV;
      rw     <= 1'b0;
      rnack  <= 1'b1;
      bitcnt <= '0;
      sr     <= 8'hFF;
      ptr    <= '0;
      wpage  <= '0;
      pvalid <= '0;
      busy   <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < PAGE_N; i++) pbuf[i] <= 8'h00;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
      if (busy != '0) busy <= busy - 1'b1;

      if (stop_c) begin
        state <= S_IDLE;
        if (|pvalid) begin
          for (int i = 0; i < PAGE_N; i++)
            if (pvalid[i]) mem[{wpage, PAGE_W'(i)}] <= pbuf[i];
          pvalid <= '0;
          busy   <= BW'(BUSY_CYCLES);
        end
      end else if (start_c) begin
        state  <= S_RX;
        kind   <= K_DEV;
        bitcnt <= '0;
      end else begin
        case (state)
          S_RX: begin
            if (rise && bitcnt < 4'd8) begin
              sr     <= {sr[6:0], sda_p[1]};
              bitcnt <= bitcnt + 1'b1;
            end else if (fall && bitcnt == 4'd8) begin
              case (kind)
                K_DEV: begin
                  rw    <= sr[0];
                  state <= dev_hit ? S_ACK : S_IDLE;
                end
                K_MEM: begin
                  ptr   <= sr;
                  wpage <= sr[ADDR_W-1:PAGE_W];
                  state <= S_ACK;
                end
                default: begin
                  pbuf[lo]   <= sr;
                  pvalid[lo] <= 1'b1;
                  ptr        <= {ptr[ADDR_W-1:PAGE_W], lo + 1'b1};
                  state      <= S_ACK;
                end
              endcase
            end
          end
          S_ACK: begin
            if (fall) begin
              bitcnt <= '0;
              if (kind == K_DEV && rw) begin
                state <= S_TX;
                sr    <= mem[ptr];
                ptr   <= ptr + 1'b1;
              end else begin
                state <= S_RX;
                kind  <= (kind == K_DEV) ? K_MEM : K_DATA;
              end
            end
          end
          S_TX: begin
            if (fall) begin
              if (bitcnt == 4'd7) state <= S_RACK;
              else begin
                sr     <= {sr[6:0], 1'b1};
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          S_RACK: begin
            if (rise) rnack <= sda_p[1];
            else if (fall) begin
              if (!rnack) begin
                state  <= S_TX;
                bitcnt <= '0;
                sr     <= mem[ptr];
                ptr    <= ptr + 1'b1;
              end else state <= S_IDLE;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_target_chk.sv
module i2c_eeprom_target_chk #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              in_idle,
  input logic              in_ack,
  input logic              in_tx,
  input logic              in_data,
  input logic              busy_on,
  input logic              stop_seen,
  input logic [ADDR_W-1:0] ptr
);
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);

  p_drive_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (in_ack || in_tx));

  p_busy_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_on |-> !sda_oe);

  p_busy_from_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_on) |-> $past(stop_seen));

  p_page_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && $past(in_data)) |-> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

  p_read_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tx && !$past(in_tx)) |-> (ptr == ADDR_W'($past(ptr) + 1'b1)));
endmodule

bind i2c_eeprom_target i2c_eeprom_target_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sda_oe    (sda_oe),
  .in_idle   (state == S_IDLE),
  .in_ack    (state == S_ACK),
  .in_tx     (state == S_TX),
  .in_data   (state != S_IDLE && kind == K_DATA),
  .busy_on   (busy != '0),
  .stop_seen (stop_c),
  .ptr       (ptr)
);

// File: tb/test_i2c_eeprom_target.sv
module test_i2c_eeprom_target;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] strap = 2'b10;
  logic       sda_oe;
  logic       sda_line;
  assign sda_line = m_sda & ~sda_oe;

  i2c_eeprom_target #(.BUSY_CYCLES(1500)) i_i2c_eeprom_target (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .strap(strap), .sda_oe(sda_oe));

  int n_tests = 0, n_fail = 0;
  logic [7:0] model [256];
  logic [7:0] mptr;
  logic [7:0] exp_q[$], got_q[$];
  string      tag_q[$];
  logic [6:0] dev = {5'b10100, 2'b10};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wq; repeat (10) @(negedge clk); endtask
  task automatic wbit(input bit b); m_sda = b; wq; m_scl = 1; wq; wq; m_scl = 0; wq; endtask
  task automatic rbit(output bit b); m_sda = 1; wq; m_scl = 1; wq; b = sda_line; wq; m_scl = 0; wq; endtask
  task automatic bstart; m_sda = 1; wq; m_scl = 1; wq; m_sda = 0; wq; m_scl = 0; wq; endtask
  task automatic bstop; m_sda = 0; wq; m_scl = 1; wq; m_sda = 1; wq; endtask

  task automatic wbyte(input logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    ack = !b;
  endtask

  task automatic read_seq(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      logic [7:0] v;
      bit b;
      exp_q.push_back(model[mptr]);
      tag_q.push_back(tag);
      mptr = mptr + 8'd1;
      for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
      got_q.push_back(v);
      wbit(k == n - 1);
    end
  endtask

  initial forever begin
    @(negedge clk);
    while (got_q.size() > 0) begin
      logic [7:0] g, e;
      string t;
      g = got_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      check(g == e, t, g, e);
    end
  end

  task automatic poll_ready(input string tag);
    int cnt = 0;
    bit ack = 0;
    while (!ack && cnt < 100) begin
      bstart; wbyte({dev, 1'b0}, ack); bstop; cnt++;
    end
    check(ack, {tag, " R9 ready"}, ack, 1);
    check(cnt > 1, {tag, " R9 refused while busy"}, cnt, 2);
  endtask

  task automatic page_write(input logic [7:0] a, input int n, input logic [7:0] seed, input string tag);
    bit ack;
    logic [3:0] lo = a[3:0];
    bstart;
    wbyte({dev, 1'b0}, ack); check(ack, {tag, " R6 address ack"}, ack, 1);
    wbyte(a, ack);           check(ack, {tag, " R6 location ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d = seed + 8'(k * 7);
      wbyte(d, ack); check(ack, {tag, " R6 data ack"}, ack, 1);
      model[{a[7:4], lo}] = d;
      lo = lo + 4'd1;
    end
    bstop;
    mptr = {a[7:4], lo};
    poll_ready(tag);
  endtask

  task automatic rand_read(input logic [7:0] a, input int n, input string tag);
    bit ack;
    bstart;
    wbyte({dev, 1'b0}, ack);
    wbyte(a, ack);
    bstart;
    wbyte({dev, 1'b1}, ack); check(ack, {tag, " R8 read address ack"}, ack, 1);
    mptr = a;
    read_seq(n, tag);
    bstop;
  endtask

  task automatic cur_read(input int n, input string tag);
    bit ack;
    bstart;
    wbyte({dev, 1'b1}, ack); check(ack, {tag, " R7 read address ack"}, ack, 1);
    read_seq(n, tag);
    bstop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit ack;
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    mptr = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0, "R1 SDA released after reset", sda_oe, 0);

    cur_read(2, "R1 R7 reset contents from counter 0");

    bstart; wbyte({5'b10100, 2'b01, 1'b0}, ack); bstop;
    check(!ack, "R2 foreign address refused", ack, 0);
    bstart; wbyte({5'b10110, 2'b10, 1'b1}, ack); bstop;
    check(!ack, "R2 wrong prefix refused", ack, 0);

    page_write(8'h20, 4, 8'h11, "R6 write");
    rand_read(8'h20, 4, "R8 random read");
    cur_read(3, "R7 current read continues");

    page_write(8'h3E, 3, 8'hA0, "R4 page wrap");
    rand_read(8'h3D, 4, "R4 wrap contents");
    rand_read(8'h30, 1, "R4 page base");

    page_write(8'h50, 18, 8'h05, "R5 overflow");
    rand_read(8'h50, 16, "R5 overwrite contents");

    page_write(8'hFE, 2, 8'hC3, "R3 top bytes");
    rand_read(8'hFE, 4, "R3 read wrap 255 to 0");

    rand_read(8'h20, 1, "R10 nack first");
    check(sda_oe == 1'b0, "R10 SDA released after nack", sda_oe, 0);
    cur_read(1, "R10 counter after nack");

    bstart; wbyte({dev, 1'b0}, ack); wbyte(8'h10, ack); bstop;
    bstart; wbyte({dev, 1'b0}, ack); bstop;
    check(ack, "R8 address-only write leaves target ready", ack, 1);

    repeat (20) @(negedge clk);
    wait (got_q.size() == 0);
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule